// File: doc/BRIEF.md
# Bit-Slip Word-Alignment Deserializer

This block turns a serial bit stream into parallel words and lets the logic downstream shift where each word starts. Serial bits are sampled on a fast bit clock. Words of `W` bits (10 by default) come out on a parallel clock that runs at exactly 1/`W` of the bit clock. A rising parallel clock edge always falls on a bit clock rising edge.

A rising edge on the slip request, seen in the parallel clock domain, adds one serial bit of delay to the path into the word. This moves the word boundary by one bit. After `W` slips the framing is back where it started. A separate slip-clear input returns the framing to zero offset. After any change of framing, and after reset, a valid flag stays low for `LAT` (4) parallel cycles. The block does not generate clocks, tune input delays, or decide when a slip is needed. A training state machine outside the block watches the words and pulses the slip input until the framing is right.

Top module: `bitslip_deser`

## Requirements
- R1: Count bit-clock rising edges from 0, where edge 0 also rises the parallel clock. Let K be the number of a parallel edge, which falls on bit edge K·W. Let `off` be the slip offset held just before edge K. After edge K, `word_o[i]` equals the serial bit sampled on bit edge (K−1)·W − 1 − off − i. Bit 0 is therefore the newest bit and bit W−1 the oldest.
- R2: When `slip_i` is high at a parallel edge after being low at the previous one, and `slip_clr_i` is low, the offset grows by exactly one. Every later word is then one serial bit older.
- R3: While `slip_i` stays high on consecutive parallel edges, only the first of those edges changes the offset.
- R4: A slip pulse that is high for one parallel cycle, followed by one low cycle and then another pulse, produces two separate slips.
- R5: The offset stays in the range 0..W−1. A slip taken at offset W−1 wraps it to 0, so W slips restore the original framing.
- R6: `slip_clr_i` high at a parallel edge sets the offset to 0. It takes priority over a slip edge at that same parallel edge.
- R7: `word_vld_o` goes low after any parallel edge where a slip edge, `slip_clr_i` or `rst` is seen. It stays low through the next three edges and is high after the fourth edge if no new event arrives.
- R8: While `rst` is high, `word_o` is 0, `word_vld_o` is 0, and the offset returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock, W times the parallel clock, phase-locked to it |
| par_clk | input | 1 | Parallel word clock |
| rst | input | 1 | Synchronous active-high reset, held for at least one parallel cycle |
| ser_i | input | 1 | Serial data, sampled on bit_clk rising edges |
| slip_i | input | 1 | Slip request; its rising edge in the par_clk domain moves the framing by one bit |
| slip_clr_i | input | 1 | Returns the framing offset to zero |
| word_o | output | W | Framed parallel word, bit 0 newest |
| word_vld_o | output | 1 | High when word_o carries data in the current framing |

## Verification
The bench keeps its own record of every serial bit and rebuilds each expected word from that record and a model offset. A design that slips in the wrong direction, or that mixes up the order of bits within a word, fails on the first framed word checked. Slip held high for several cycles catches a design that slips on level rather than on edge. Back-to-back one-cycle pulses catch a design that loses the second edge. A run of exactly W slips catches an offset that fails to wrap or wraps one step late. A clear that arrives at the same edge as a slip edge checks that the clear wins. Every cycle the valid flag is compared against a four-edge window; a counter that is one short or one long shows up as a mismatch at the edge of that window.

// File: rtl/bitslip_pkg.sv
`timescale 1ns/1ps
package bitslip_pkg;
  // Event seen by the framing control at one parallel edge
  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_SLIP  = 2'd1,
    EV_CLEAR = 2'd2
  } slip_ev_e;
endpackage

// File: rtl/bs_shift_capture.sv
`timescale 1ns/1ps
// Bit-domain history: newest bit at index 0
module bs_shift_capture #(
  parameter int W = 10
) (
  input  logic           bit_clk,
  input  logic           rst,
  input  logic           ser_i,
  output logic [2*W-1:0] hist_o
);
  localparam int HW = 2 * W;

  always_ff @(posedge bit_clk) begin
    if (rst) hist_o <= '0;
    else     hist_o <= {hist_o[HW-2:0], ser_i};
  end
endmodule

// File: rtl/bs_slip_ctrl.sv
`timescale 1ns/1ps
// Parallel-domain framing control: edge detect, offset, settle counter
module bs_slip_ctrl
  import bitslip_pkg::*;
#(
  parameter int W     = 10,
  parameter int LAT   = 4,
  parameter int OFF_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic             par_clk,
  input  logic             rst,
  input  logic             slip_i,
  input  logic             slip_clr_i,
  output logic [OFF_W-1:0] off_o,
  output logic             vld_o
);
  localparam int CNT_W = (LAT > 1) ? $clog2(LAT + 1) : 1;
  localparam logic [OFF_W-1:0] OFF_MAX  = OFF_W'(W - 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LAT - 1);

  logic             slip_q;
  logic [CNT_W-1:0] settle;
  slip_ev_e         ev;

  always_comb begin
    if (slip_clr_i)           ev = EV_CLEAR;
    else if (slip_i && !slip_q) ev = EV_SLIP;
    else                      ev = EV_NONE;
  end

  always_ff @(posedge par_clk) begin
    if (rst) begin
      slip_q <= 1'b0;
      off_o  <= '0;
      settle <= CNT_LOAD;
      vld_o  <= 1'b0;
    end else begin
      slip_q <= slip_i;
      case (ev)
        EV_CLEAR: begin
          off_o  <= '0;
          settle <= CNT_LOAD;
          vld_o  <= 1'b0;
        end
        EV_SLIP: begin
          off_o  <= (off_o == OFF_MAX) ? '0 : off_o + 1'b1;
          settle <= CNT_LOAD;
          vld_o  <= 1'b0;
        end
        default: begin
          vld_o <= (settle == '0);
          if (settle != '0) settle <= settle - 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/bs_window.sv
`timescale 1ns/1ps
// Parallel-domain snapshot of the bit history and offset-selected window
module bs_window #(
  parameter int W     = 10,
  parameter int OFF_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic             par_clk,
  input  logic             rst,
  input  logic [2*W-1:0]   hist_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [W-1:0]     word_o
);
  logic [2*W-1:0] snap;
  logic [W-1:0]   sel;

  // one selector per output bit
  for (genvar i = 0; i < W; i++) begin : g_sel
    assign sel[i] = snap[int'(off_i) + i];
  end

  always_ff @(posedge par_clk) begin
    if (rst) begin
      snap   <= '0;
      word_o <= '0;
    end else begin
      snap   <= hist_i;
      word_o <= sel;
    end
  end
endmodule

// File: rtl/bitslip_deser.sv
`timescale 1ns/1ps
module bitslip_deser #(
  parameter int W   = 10,
  parameter int LAT = 4
) (
  input  logic         bit_clk,
  input  logic         par_clk,
  input  logic         rst,
  input  logic         ser_i,
  input  logic         slip_i,
  input  logic         slip_clr_i,
  output logic [W-1:0] word_o,
  output logic         word_vld_o
);
  localparam int OFF_W = (W > 1) ? $clog2(W) : 1;

  logic [2*W-1:0]   hist;
  logic [OFF_W-1:0] slip_off;

  bs_shift_capture #(.W(W)) u_cap (
    .bit_clk (bit_clk),
    .rst     (rst),
    .ser_i   (ser_i),
    .hist_o  (hist)
  );

  bs_slip_ctrl #(.W(W), .LAT(LAT), .OFF_W(OFF_W)) u_ctrl (
    .par_clk    (par_clk),
    .rst        (rst),
    .slip_i     (slip_i),
    .slip_clr_i (slip_clr_i),
    .off_o      (slip_off),
    .vld_o      (word_vld_o)
  );

  bs_window #(.W(W), .OFF_W(OFF_W)) u_win (
    .par_clk (par_clk),
    .rst     (rst),
    .hist_i  (hist),
    .off_i   (slip_off),
    .word_o  (word_o)
  );
endmodule

// File: rtl/bitslip_deser_chk.sv
`timescale 1ns/1ps
module bitslip_deser_chk #(
  parameter int W     = 10,
  parameter int LAT   = 4,
  parameter int OFF_W = (W > 1) ? $clog2(W) : 1
) (
  input logic             par_clk,
  input logic             rst,
  input logic             slip_i,
  input logic             slip_clr_i,
  input logic             word_vld_o,
  input logic [OFF_W-1:0] off
);
  localparam int SW = $clog2(LAT + 2);

  logic          slip_d;
  logic [SW-1:0] since;

  always_ff @(posedge par_clk) begin
    if (rst) begin
      slip_d <= 1'b0;
      since  <= '0;
    end else begin
      slip_d <= slip_i;
      if (slip_clr_i || (slip_i && !slip_d)) since <= '0;
      else if (int'(since) < LAT)            since <= since + 1'b1;
    end
  end

  assert_slip_step_R2: assert property (@(posedge par_clk) disable iff (rst)
    (slip_i && !slip_d && !slip_clr_i) |=>
      (off == (($past(off) == OFF_W'(W - 1)) ? '0 : $past(off) + 1'b1)));

  assert_hold_R3: assert property (@(posedge par_clk) disable iff (rst)
    (slip_i && slip_d && !slip_clr_i) |=> $stable(off));

  assert_off_range_R5: assert property (@(posedge par_clk) disable iff (rst)
    int'(off) < W);

  assert_clear_R6: assert property (@(posedge par_clk) disable iff (rst)
    slip_clr_i |=> (off == '0 && !word_vld_o));

  assert_settle_R7: assert property (@(posedge par_clk) disable iff (rst)
    word_vld_o == (int'(since) >= LAT));
endmodule

bind bitslip_deser bitslip_deser_chk #(.W(W), .LAT(LAT)) u_chk (
  .par_clk    (par_clk),
  .rst        (rst),
  .slip_i     (slip_i),
  .slip_clr_i (slip_clr_i),
  .word_vld_o (word_vld_o),
  .off        (slip_off)
);

// File: tb/bitslip_deser_tb.sv
`timescale 1ns/1ps
module bitslip_deser_tb;
  localparam int N    = 10;
  localparam int LAT  = 4;
  localparam int HMAX = 40000;

  logic         bit_clk, par_clk, rst, ser, slip, clr;
  logic [N-1:0] word;
  logic         vld;

  bit    hist [HMAX];
  int    kedge;
  int    total, bad;
  string tag;
  bit    done;

  // model of the requirements
  bit m_slipq;
  int m_off, m_offp, m_since;

  bitslip_deser #(.W(N), .LAT(LAT)) u_dut (
    .bit_clk    (bit_clk),
    .par_clk    (par_clk),
    .rst        (rst),
    .ser_i      (ser),
    .slip_i     (slip),
    .slip_clr_i (clr),
    .word_o     (word),
    .word_vld_o (vld)
  );

  // bit stream and locked clocks: par edge K sits on bit edge K*N
  initial begin
    void'($urandom(32'd20240611));
    for (int g = 0; g < HMAX; g++)
      hist[g] = (g >= 6000 && g < 9000) ? (g % 23 == 0) : 1'($urandom_range(1));
    bit_clk = 0; par_clk = 0; ser = 0; kedge = 0;
    for (int g = 0; g < HMAX; g++) begin
      ser = hist[g];
      #1;
      bit_clk = 1;
      if (g % N == 0) begin
        par_clk = 1;
        kedge   = g / N;
      end
      #1;
      bit_clk = 0;
      if (g % N == N / 2) par_clk = 0;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s edge=%0d act=%h exp=%h", req, kedge, act, exp);
    end
  endtask

  task automatic model_update();
    m_offp = m_off;
    if (rst) begin
      m_slipq = 0; m_off = 0; m_since = 0;
    end else begin
      if (clr) begin
        m_off = 0; m_since = 0;
      end else if (slip && !m_slipq) begin
        m_off = (m_off + 1) % N; m_since = 0;
      end else if (m_since < 100) begin
        m_since++;
      end
      m_slipq = slip;
    end
  endtask

  task automatic step();
    logic [N-1:0] e;
    bit           ev;
    @(negedge par_clk);
    #1;
    model_update();
    ev = (m_since >= LAT);
    check("R7 valid", 32'(vld), 32'(ev));
    if (rst) begin
      check("R8 word in reset", 32'(word), 32'd0);
    end else if (ev) begin
      for (int i = 0; i < N; i++) e[i] = hist[(kedge - 1) * N - 1 - m_offp - i];
      check(tag, 32'(word), 32'(e));
    end
  endtask

  initial begin
    total = 0; bad = 0; done = 0;
    rst = 1; slip = 0; clr = 0;
    m_slipq = 0; m_off = 0; m_offp = 0; m_since = 0;
    tag = "R8";
    repeat (3) step();
    rst = 0;
    tag = "R1 plain framing";
    repeat (12) step();
    tag = "R2 single slip";
    slip = 1; step(); slip = 0; repeat (8) step();
    tag = "R3 held slip";
    slip = 1; repeat (7) step(); slip = 0; repeat (6) step();
    tag = "R4 short pulses";
    slip = 1; step(); slip = 0; step(); slip = 1; step(); slip = 0; repeat (6) step();
    tag = "R5 wrap";
    repeat (N) begin slip = 1; step(); slip = 0; step(); end
    repeat (6) step();
    tag = "R6 clear";
    slip = 1; step(); slip = 0; step(); clr = 1; step(); clr = 0; repeat (6) step();
    slip = 1; clr = 1; step(); slip = 0; clr = 0; repeat (6) step();
    tag = "R7 random";
    repeat (1500) begin
      slip = ($urandom_range(99) < 15);
      clr  = ($urandom_range(99) < 3);
      step();
    end
    slip = 0; clr = 0; repeat (6) step();
    tag = "R8 mid-run reset";
    slip = 1; step(); slip = 0; step();
    rst = 1; slip = 1; repeat (2) step();
    rst = 0; slip = 0; repeat (10) step();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(HMAX * 2 + 100);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule